// File: doc/BRIEF.md
# DDR Power-Up Initialization Sequencer

This block sits on the controller side of a DDR memory interface and owns the clock-enable, command, bank and address lines from reset until the memory is ready for normal traffic. Once reset is released it keeps the memory's clock disabled for a long, programmable settling period. It then enables the clock and issues a fixed chain of commands: an extended register write that switches the delay-locked loop on, a mode register write that resets that loop, a precharge of every bank, a programmable number of auto refreshes, and a final mode register write that carries the operating burst and latency settings.

Each command is followed by no-operation cycles for at least the minimum gap that the command requires. A separate counter measures the lock time of the delay-locked loop, starting at the loop-reset write. The done flag rises only when the gap after the final register write has passed and the lock time has also run out. After that, the normal controller takes over the bus. Reset restarts the whole chain from the beginning at any point.

Top module: `ddr_init_seq`

## Requirements
- R1: For the first STAB_CYCLES sampled cycles after reset release, cke is low and the command lines carry NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111).
- R2: At cycle STAB_CYCLES cke goes high and stays high. NOP continues for CKE_WAIT cycles before the first command.
- R3: The first command is a register write ({cs_n,ras_n,cas_n,we_n} = 4'b0000) with ba = 1 and addr equal to EXT_WORD with bit 0 forced low, so that the delay-locked loop is enabled.
- R4: MRD_CYCLES after R3, a register write with ba = 0 and addr equal to MODE_WORD with bit 8 forced high resets the delay-locked loop. Register writes are never closer than MRD_CYCLES.
- R5: MRD_CYCLES after R4, a precharge (4'b0010) with addr bit 10 high and ba = 0 closes all banks.
- R6: REFRESH_COUNT auto refreshes (4'b0001, ba = 0, addr = 0) follow. The first comes RP_CYCLES after the precharge and each further one comes RFC_CYCLES after the one before.
- R7: RFC_CYCLES after the last refresh, a register write with ba = 0 and addr equal to MODE_WORD with bit 8 forced low sets the operating mode.
- R8: done rises in the later of two cycles: MRD_CYCLES after the R7 write, or LOCK_CYCLES after the R4 write. Every cycle without a command drives NOP with ba and addr zero.
- R9: An active-low asynchronous reset forces cke low, NOP, zero ba and addr, and done low. On release the sequence restarts at R1.
- R10: Once done is high it stays high, with cke high and NOP on the command lines, until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the sequence |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank select; bit 0 high picks the extended register |
| addr | output | ADDR_W | Address and register payload |
| done | output | 1 | Initialization complete; the bus may be handed over |

## Verification
Two things can end in the same cycle: the gap after the final register write, and the lock wait that started at the loop-reset write. The bench runs three parameter sets side by side. In the first, the lock wait finishes last. In the second, the final gap finishes last. In the third, both run out on the same edge. For each set, a cycle-exact schedule computed from R1 to R8 predicts the cycle in which done rises, and the bench compares every output against that schedule in every cycle. Random resets dropped into the middle of the sequences confirm that both counters start again from zero.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    // Command codes laid out as {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } ddr_cmd_e;

    // Sequencer states, each named after the command it issues next
    typedef enum logic [2:0] {
        ST_PWR,
        ST_EMRS,
        ST_DLL,
        ST_PRE,
        ST_REF,
        ST_OP,
        ST_TAIL,
        ST_DONE
    } seq_state_e;

    // Command selected in the current cycle
    typedef enum logic [2:0] {
        STEP_NONE,
        STEP_EMRS,
        STEP_DLL,
        STEP_PRE,
        STEP_REF,
        STEP_OP
    } step_e;

    localparam int DLL_OFF_BIT = 0;
    localparam int DLL_RST_BIT = 8;
    localparam int ALL_BANK_BIT = 10;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
    parameter int W    = 8,
    parameter int INIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(INIT);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_fmt.sv
module ddr_init_fmt
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0,
    parameter logic [ADDR_W-1:0] EXT_WORD  = '0
) (
    input  step_e             step,
    output ddr_cmd_e          cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        case (step)
            STEP_EMRS: begin
                cmd  = CMD_LMR;
                ba   = BA_W'(1);
                addr = EXT_WORD;
                addr[DLL_OFF_BIT] = 1'b0;
            end
            STEP_DLL: begin
                cmd  = CMD_LMR;
                addr = MODE_WORD;
                addr[DLL_RST_BIT] = 1'b1;
            end
            STEP_PRE: begin
                cmd  = CMD_PRE;
                addr[ALL_BANK_BIT] = 1'b1;
            end
            STEP_REF: begin
                cmd  = CMD_REF;
            end
            STEP_OP: begin
                cmd  = CMD_LMR;
                addr = MODE_WORD;
                addr[DLL_RST_BIT] = 1'b0;
            end
            default: begin
                cmd  = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W        = 12,
    parameter int BA_W          = 2,
    parameter int STAB_CYCLES   = 20000,
    parameter int CKE_WAIT      = 4,
    parameter int MRD_CYCLES    = 2,
    parameter int RP_CYCLES     = 4,
    parameter int RFC_CYCLES    = 15,
    parameter int REFRESH_COUNT = 2,
    parameter int LOCK_CYCLES   = 200,
    parameter logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(12'h032),
    parameter logic [ADDR_W-1:0] EXT_WORD  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);

    localparam int SPAN = STAB_CYCLES + CKE_WAIT + MRD_CYCLES + RP_CYCLES
                        + RFC_CYCLES + LOCK_CYCLES;
    localparam int TW = $clog2(SPAN + 1);
    localparam int RW = $clog2(REFRESH_COUNT + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [RW-1:0]     refs;
        logic              cke;
        ddr_cmd_e          cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    step_e             step;
    ddr_cmd_e          fmt_cmd;
    logic [BA_W-1:0]   fmt_ba;
    logic [ADDR_W-1:0] fmt_addr;
    logic              st_load, st_exp;
    logic [TW-1:0]     st_val;
    logic              lk_load, lk_exp;

    // Gap timer shared by all steps; starts with the settling delay
    ddr_init_timer #(
        .W    (TW),
        .INIT (STAB_CYCLES - 1)
    ) stage_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st_load),
        .load_val (st_val),
        .expired  (st_exp)
    );

    // Lock wait runs beside the remaining steps
    ddr_init_timer #(
        .W    (TW),
        .INIT (0)
    ) lock_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lk_load),
        .load_val (TW'(LOCK_CYCLES - 1)),
        .expired  (lk_exp)
    );

    ddr_init_fmt #(
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W),
        .MODE_WORD (MODE_WORD),
        .EXT_WORD  (EXT_WORD)
    ) fmt_i (
        .step (step),
        .cmd  (fmt_cmd),
        .ba   (fmt_ba),
        .addr (fmt_addr)
    );

    always_comb begin
        r_d     = r_q;
        step    = STEP_NONE;
        st_load = 1'b0;
        st_val  = '0;
        lk_load = 1'b0;
        case (r_q.state)
            ST_PWR: begin
                if (st_exp) begin
                    r_d.state = ST_EMRS;
                    st_load   = 1'b1;
                    st_val    = TW'(CKE_WAIT - 1);
                end
            end
            ST_EMRS: begin
                if (st_exp) begin
                    step      = STEP_EMRS;
                    r_d.state = ST_DLL;
                    st_load   = 1'b1;
                    st_val    = TW'(MRD_CYCLES - 1);
                end
            end
            ST_DLL: begin
                if (st_exp) begin
                    step      = STEP_DLL;
                    r_d.state = ST_PRE;
                    st_load   = 1'b1;
                    st_val    = TW'(MRD_CYCLES - 1);
                    lk_load   = 1'b1;
                end
            end
            ST_PRE: begin
                if (st_exp) begin
                    step      = STEP_PRE;
                    r_d.state = ST_REF;
                    r_d.refs  = '0;
                    st_load   = 1'b1;
                    st_val    = TW'(RP_CYCLES - 1);
                end
            end
            ST_REF: begin
                if (st_exp) begin
                    step    = STEP_REF;
                    st_load = 1'b1;
                    st_val  = TW'(RFC_CYCLES - 1);
                    if (r_q.refs == RW'(REFRESH_COUNT - 1)) begin
                        r_d.state = ST_OP;
                    end else begin
                        r_d.refs = r_q.refs + 1'b1;
                    end
                end
            end
            ST_OP: begin
                if (st_exp) begin
                    step      = STEP_OP;
                    r_d.state = ST_TAIL;
                    st_load   = 1'b1;
                    st_val    = TW'(MRD_CYCLES - 1);
                end
            end
            ST_TAIL: begin
                if (st_exp && lk_exp) begin
                    r_d.state = ST_DONE;
                end
            end
            default: begin
                r_d.state = ST_DONE;
            end
        endcase
        r_d.cke  = (r_d.state != ST_PWR);
        r_d.cmd  = fmt_cmd;
        r_d.ba   = fmt_ba;
        r_d.addr = fmt_addr;
        r_d.done = (r_d.state == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_PWR;
            r_q.refs  <= '0;
            r_q.cke   <= 1'b0;
            r_q.cmd   <= CMD_NOP;
            r_q.ba    <= '0;
            r_q.addr  <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cke   = r_q.cke;
    assign cs_n  = r_q.cmd[3];
    assign ras_n = r_q.cmd[2];
    assign cas_n = r_q.cmd[1];
    assign we_n  = r_q.cmd[0];
    assign ba    = r_q.ba;
    assign addr  = r_q.addr;
    assign done  = r_q.done;

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
    parameter int ADDR_W     = 12,
    parameter int BA_W       = 2,
    parameter int MRD_CYCLES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              done
);

    localparam int GW = $clog2(MRD_CYCLES + 1);

    logic [3:0] pins;
    logic       nop, lmr, pre;
    logic [GW-1:0] since_q;

    assign pins = {cs_n, ras_n, cas_n, we_n};
    assign nop  = (pins == 4'b0111);
    assign lmr  = (pins == 4'b0000);
    assign pre  = (pins == 4'b0010);

    // Cycles since the last register write, saturating at the minimum gap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= GW'(MRD_CYCLES);
        end else begin
            if (lmr) begin
                p_lmr_gap_r4: assert (since_q >= GW'(MRD_CYCLES - 1))
                    else $error("register writes closer than the minimum gap");
            end
            if (lmr) begin
                since_q <= '0;
            end else if (since_q < GW'(MRD_CYCLES)) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    p_idle_while_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> nop);

    p_cke_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    p_dll_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lmr && ba == BA_W'(1)) |-> !addr[0]);

    p_pre_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pre |-> (addr[10] && ba == '0));

    p_nop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nop |-> (addr == '0 && ba == '0));

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && cke && nop));

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
    .ADDR_W     (ADDR_W),
    .BA_W       (BA_W),
    .MRD_CYCLES (MRD_CYCLES)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .ba    (ba),
    .addr  (addr),
    .done  (done)
);

// File: tb/ddr_init_mon.sv
module ddr_init_mon #(
    parameter string NAME          = "seq",
    parameter int    STAB_CYCLES   = 20000,
    parameter int    CKE_WAIT      = 4,
    parameter int    MRD_CYCLES    = 2,
    parameter int    RP_CYCLES     = 4,
    parameter int    RFC_CYCLES    = 15,
    parameter int    REFRESH_COUNT = 2,
    parameter int    LOCK_CYCLES   = 200,
    parameter logic [11:0] MODE_WORD = 12'h032,
    parameter logic [11:0] EXT_WORD  = 12'h000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cke,
    input  logic        cs_n,
    input  logic        ras_n,
    input  logic        cas_n,
    input  logic        we_n,
    input  logic [1:0]  ba,
    input  logic [11:0] addr,
    input  logic        done,
    output int          n_chk,
    output int          n_fail
);

    localparam int T_EMRS = STAB_CYCLES + CKE_WAIT;
    localparam int T_DLL  = T_EMRS + MRD_CYCLES;
    localparam int T_PRE  = T_DLL + MRD_CYCLES;
    localparam int T_REF0 = T_PRE + RP_CYCLES;
    localparam int T_OP   = T_REF0 + REFRESH_COUNT * RFC_CYCLES;
    localparam int T_DONE = (T_OP + MRD_CYCLES > T_DLL + LOCK_CYCLES) ?
                            (T_OP + MRD_CYCLES) : (T_DLL + LOCK_CYCLES);

    int cyc;
    bit armed;

    initial begin
        n_chk  = 0;
        n_fail = 0;
        armed  = 1'b0;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(posedge clk) armed <= 1'b1;

    function automatic bit is_ref(int c);
        for (int i = 0; i < REFRESH_COUNT; i++) begin
            if (c == T_REF0 + i * RFC_CYCLES) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Expected {cke, cs_n, ras_n, cas_n, we_n, ba, addr, done}
    function automatic logic [19:0] expect_at(int c);
        logic [3:0]  cmd = 4'b0111;
        logic [1:0]  eba = 2'd0;
        logic [11:0] ead = 12'h000;
        if (c == T_EMRS) begin
            cmd = 4'b0000; eba = 2'd1; ead = EXT_WORD & ~12'h001;
        end else if (c == T_DLL) begin
            cmd = 4'b0000; ead = MODE_WORD | 12'h100;
        end else if (c == T_PRE) begin
            cmd = 4'b0010; ead = 12'h400;
        end else if (is_ref(c)) begin
            cmd = 4'b0001;
        end else if (c == T_OP) begin
            cmd = 4'b0000; ead = MODE_WORD & ~12'h100;
        end
        return {(c >= STAB_CYCLES), cmd, eba, ead, (c >= T_DONE)};
    endfunction

    function automatic string tag_of(int c);
        if (c < STAB_CYCLES) return "R1";
        if (c < T_EMRS)      return "R2";
        if (c == T_EMRS)     return "R3";
        if (c == T_DLL)      return "R4";
        if (c == T_PRE)      return "R5";
        if (is_ref(c))       return "R6";
        if (c == T_OP)       return "R7";
        if (c > T_DONE)      return "R10";
        return "R8";
    endfunction

    always @(negedge clk) begin
        logic [19:0] act;
        logic [19:0] exp_v;
        act = {cke, cs_n, ras_n, cas_n, we_n, ba, addr, done};
        if (armed) begin
            n_chk = n_chk + 1;
            if (!rst_n) begin
                exp_v = {1'b0, 4'b0111, 2'd0, 12'h000, 1'b0};
                if (act !== exp_v) begin
                    n_fail = n_fail + 1;
                    $display("FAIL R9 %s in reset: actual %h expected %h", NAME, act, exp_v);
                end
            end else begin
                exp_v = expect_at(cyc);
                if (act !== exp_v) begin
                    n_fail = n_fail + 1;
                    $display("FAIL %s %s cycle %0d: actual %h expected %h",
                             tag_of(cyc), NAME, cyc, act, exp_v);
                end
            end
        end
    end

endmodule

// File: tb/ddr_init_seq_tb_top.sv
module ddr_init_seq_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // Instance outputs: a = lock wait last, b = final gap last, c = both together
    logic        cke_a, cs_a, ras_a, cas_a, we_a, done_a;
    logic [1:0]  ba_a;
    logic [11:0] ad_a;
    logic        cke_b, cs_b, ras_b, cas_b, we_b, done_b;
    logic [1:0]  ba_b;
    logic [11:0] ad_b;
    logic        cke_c, cs_c, ras_c, cas_c, we_c, done_c;
    logic [1:0]  ba_c;
    logic [11:0] ad_c;

    int own_chk = 0;
    int own_fail = 0;
    int mc_a, mf_a, mc_b, mf_b, mc_c, mf_c;

    ddr_init_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cke(cke_a), .cs_n(cs_a), .ras_n(ras_a),
        .cas_n(cas_a), .we_n(we_a), .ba(ba_a), .addr(ad_a), .done(done_a)
    );

    ddr_init_seq #(
        .STAB_CYCLES(50), .CKE_WAIT(3), .MRD_CYCLES(3), .RP_CYCLES(3),
        .RFC_CYCLES(7), .REFRESH_COUNT(3), .LOCK_CYCLES(10),
        .MODE_WORD(12'h03B), .EXT_WORD(12'h043)
    ) dut_b (
        .clk(clk), .rst_n(rst_n), .cke(cke_b), .cs_n(cs_b), .ras_n(ras_b),
        .cas_n(cas_b), .we_n(we_b), .ba(ba_b), .addr(ad_b), .done(done_b)
    );

    ddr_init_seq #(
        .STAB_CYCLES(30), .CKE_WAIT(1), .MRD_CYCLES(2), .RP_CYCLES(2),
        .RFC_CYCLES(5), .REFRESH_COUNT(2), .LOCK_CYCLES(16),
        .MODE_WORD(12'h122), .EXT_WORD(12'h001)
    ) dut_c (
        .clk(clk), .rst_n(rst_n), .cke(cke_c), .cs_n(cs_c), .ras_n(ras_c),
        .cas_n(cas_c), .we_n(we_c), .ba(ba_c), .addr(ad_c), .done(done_c)
    );

    ddr_init_mon #(.NAME("a")) mon_a (
        .clk(clk), .rst_n(rst_n), .cke(cke_a), .cs_n(cs_a), .ras_n(ras_a),
        .cas_n(cas_a), .we_n(we_a), .ba(ba_a), .addr(ad_a), .done(done_a),
        .n_chk(mc_a), .n_fail(mf_a)
    );

    ddr_init_mon #(
        .NAME("b"), .STAB_CYCLES(50), .CKE_WAIT(3), .MRD_CYCLES(3), .RP_CYCLES(3),
        .RFC_CYCLES(7), .REFRESH_COUNT(3), .LOCK_CYCLES(10),
        .MODE_WORD(12'h03B), .EXT_WORD(12'h043)
    ) mon_b (
        .clk(clk), .rst_n(rst_n), .cke(cke_b), .cs_n(cs_b), .ras_n(ras_b),
        .cas_n(cas_b), .we_n(we_b), .ba(ba_b), .addr(ad_b), .done(done_b),
        .n_chk(mc_b), .n_fail(mf_b)
    );

    ddr_init_mon #(
        .NAME("c"), .STAB_CYCLES(30), .CKE_WAIT(1), .MRD_CYCLES(2), .RP_CYCLES(2),
        .RFC_CYCLES(5), .REFRESH_COUNT(2), .LOCK_CYCLES(16),
        .MODE_WORD(12'h122), .EXT_WORD(12'h001)
    ) mon_c (
        .clk(clk), .rst_n(rst_n), .cke(cke_c), .cs_n(cs_c), .ras_n(ras_c),
        .cas_n(cas_c), .we_n(we_c), .ba(ba_c), .addr(ad_c), .done(done_c),
        .n_chk(mc_c), .n_fail(mf_c)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        own_chk++;
        if (!ok) begin
            own_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
        end
    endtask

    task automatic summary();
        int tot;
        int bad;
        tot = own_chk + mc_a + mc_b + mc_c;
        bad = own_fail + mf_a + mf_b + mf_c;
        $display("%0d/%0d checks passed", tot - bad, tot);
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (150000) @(posedge clk);
        own_chk++;
        own_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Full sequences; monitors compare every cycle (R1..R8)
        repeat (20400) @(posedge clk);
        @(negedge clk);
        check(done_a === 1'b1, "R8 done a (lock wait last)", done_a, 1);
        check(done_b === 1'b1, "R8 done b (final gap last)", done_b, 1);
        check(done_c === 1'b1, "R8 done c (both on one edge)", done_c, 1);
        check(cke_a === 1'b1 && {cs_a, ras_a, cas_a, we_a} === 4'b0111,
              "R10 idle after done", {cke_a, cs_a, ras_a, cas_a, we_a}, 5'h17);

        // Random reset pulses landing mid-sequence (R9)
        for (int k = 0; k < 8; k++) begin
            repeat ($urandom_range(20, 300)) @(posedge clk);
            #1 rst_n = 1'b0;
            @(negedge clk);
            check(cke_b === 1'b0 && done_b === 1'b0, "R9 reset b",
                  {cke_b, done_b}, 0);
            check({cs_c, ras_c, cas_c, we_c} === 4'b0111 && ad_c === 12'h000,
                  "R9 reset c", {cs_c, ras_c, cas_c, we_c, ad_c}, 16'h7000);
            check(done_a === 1'b0, "R9 reset a", done_a, 0);
            repeat ($urandom_range(1, 3)) @(posedge clk);
            #1 rst_n = 1'b1;
        end

        // Restart from scratch after the last pulse
        repeat (20400) @(posedge clk);
        @(negedge clk);
        check(done_a === 1'b1, "R9 restart a reaches done", done_a, 1);
        check(done_b === 1'b1, "R9 restart b reaches done", done_b, 1);
        check(done_c === 1'b1, "R9 restart c reaches done", done_c, 1);
        summary();
        $finish;
    end

endmodule